// File: doc/BRIEF.md
# Real-time clock prescaler with partial stop gating

This block turns a 32,768 Hz clock into the slower timing events that a real-time clock needs. A binary counter runs on the input clock. Each counter bit is one divide-by-2 stage. Each stage gives a one-cycle tap enable when its bit falls from 1 to 0. When the whole counter wraps, the block gives a one-cycle 1 Hz tick enable, which advances the calendar counters further on. The taps and the tick are enables in the input clock domain, not derived clocks.

The stop input freezes only the slower stages, from the 8,192 Hz stage downward. The lowest stage (16,384 Hz) keeps toggling. While the stop input is high, carries out of the lowest stage are dropped. When the stop input falls, counting resumes from the held value. A software-reset input, held for at least one cycle and then released, clears the whole counter, including the lowest stage. While it is high, it also holds the registered interrupt request output low. That output can only be high when the counter-enable input is set. After the software reset is released, the counter starts again from zero, so the next tick comes one full period later.

Top module: `rtc_prescaler`

## Requirements
- R1: After the synchronous reset `rst`, all taps, `tick_o` and `irq_o` are 0. Counting from the first clock edge with `rst` low, the first tick appears after exactly 2^DIV_BITS edges.
- R2: The lowest FREE_BITS stages advance on every edge, whatever the value of `stop_i`, unless `swrst_i` is high. With FREE_BITS = 1, `tap_o[0]` is high on every second cycle.
- R3: Bit i of `tap_o` pulses for one cycle after each edge on which counter bit i falls from 1 to 0. While running, this happens once every 2^(i+1) edges.
- R4: `tick_o` is a one-cycle pulse after each edge on which the counter wraps from all ones to zero. While running, this happens once every 2^DIV_BITS edges, and every bit of `tap_o` is high in the same cycle.
- R5: While `stop_i` is 1, the stages at positions FREE_BITS and above hold their value. Carries from the free stages are lost, and those upper tap bits and `tick_o` stay 0.
- R6: When `stop_i` returns to 0, the upper stages resume from the value they held.
- R7: While `swrst_i` is 1, the whole counter is cleared on each edge, and `tap_o` and `tick_o` are 0 from the next cycle on. After release, counting restarts from zero, and the first tick comes 2^DIV_BITS edges after the first edge with `swrst_i` low.
- R8: `irq_o` is `irq_req_i` AND `cnt_en_i` AND NOT `swrst_i`, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32,768 Hz input clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | 1 freezes the gated stages, 0 lets them count |
| swrst_i | input | 1 | Software reset; while high, clears the counter and masks the interrupt |
| cnt_en_i | input | 1 | Counter enable; qualifies the interrupt request |
| irq_req_i | input | 1 | Interrupt request from the source-selection logic |
| tap_o | output | DIV_BITS | One-cycle fall enable for each divider stage |
| tick_o | output | 1 | One-cycle 1 Hz enable at the counter wrap |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach from the ports is stop asserted on the very edge where the free stage carries. The free bit must still wrap, the upper bits must hold, and a later release must resume from the held value without a lost or doubled step. A small configuration with a 6-bit divider makes every carry position reachable within a short run. A bench-side LFSR then toggles stop and software reset at irregular phases, and an arithmetic model of the counter predicts every tap, tick and interrupt value on every cycle. Directed phases also measure the distance to the first tick after reset and after a software-reset release.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;
  localparam int DEF_DIV_BITS  = 15;
  localparam int DEF_FREE_BITS = 1;
endpackage

// File: rtl/rtc_pre_free_stage.sv
module rtc_pre_free_stage #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt_o,
  output logic         carry_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] nxt;

  always_comb nxt = clr ? '0 : cnt_o + 1'b1;
  assign carry_o = &cnt_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      fall_o <= '0;
    end else begin
      cnt_o  <= nxt;
      fall_o <= clr ? '0 : (cnt_o & ~nxt);
    end
  end

  AST_FREE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt_o[0] != $past(cnt_o[0]))); // R2
endmodule

// File: rtl/rtc_pre_gated_stage.sv
module rtc_pre_gated_stage #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         carry_i,
  input  logic         stop_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] fall_o
);
  logic         adv;
  logic [W-1:0] nxt;

  assign adv = carry_i & ~stop_i;

  always_comb begin
    if (clr)      nxt = '0;
    else if (adv) nxt = cnt_o + 1'b1;
    else          nxt = cnt_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      fall_o <= '0;
    end else begin
      cnt_o  <= nxt;
      fall_o <= clr ? '0 : (cnt_o & ~nxt);
    end
  end

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !clr) |=> $stable(cnt_o)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr && carry_i && !stop_i) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R3
endmodule

// File: rtl/rtc_pre_irq_gate.sv
module rtc_pre_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic swrst_i,
  input  logic cnt_en_i,
  input  logic irq_req_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irq_req_i & cnt_en_i & ~swrst_i;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    swrst_i |=> !irq_o); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !cnt_en_i |=> !irq_o); // R8
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pre_pkg::*;
#(
  parameter int DIV_BITS  = DEF_DIV_BITS,
  parameter int FREE_BITS = DEF_FREE_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stop_i,
  input  logic                swrst_i,
  input  logic                cnt_en_i,
  input  logic                irq_req_i,
  output logic [DIV_BITS-1:0] tap_o,
  output logic                tick_o,
  output logic                irq_o
);
  localparam int GATED_BITS = DIV_BITS - FREE_BITS;

  logic [FREE_BITS-1:0]  free_cnt;
  logic [FREE_BITS-1:0]  free_fall;
  logic                  free_carry;
  logic [GATED_BITS-1:0] gated_cnt;
  logic [GATED_BITS-1:0] gated_fall;
  logic                  wrap_now;

  rtc_pre_free_stage #(.W(FREE_BITS)) u_free (
    .clk     (clk),
    .rst     (rst),
    .clr     (swrst_i),
    .cnt_o   (free_cnt),
    .carry_o (free_carry),
    .fall_o  (free_fall)
  );

  rtc_pre_gated_stage #(.W(GATED_BITS)) u_gated (
    .clk     (clk),
    .rst     (rst),
    .clr     (swrst_i),
    .carry_i (free_carry),
    .stop_i  (stop_i),
    .cnt_o   (gated_cnt),
    .fall_o  (gated_fall)
  );

  rtc_pre_irq_gate u_irq (
    .clk       (clk),
    .rst       (rst),
    .swrst_i   (swrst_i),
    .cnt_en_i  (cnt_en_i),
    .irq_req_i (irq_req_i),
    .irq_o     (irq_o)
  );

  assign tap_o    = {gated_fall, free_fall};
  assign wrap_now = (&free_cnt) & (&gated_cnt) & ~stop_i & ~swrst_i;

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= wrap_now;
  end

  AST_TICK_TAPS: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (&tap_o)); // R4
  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    swrst_i |=> (tap_o == '0 && !tick_o)); // R7
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !tick_o); // R5
endmodule

// File: tb/sim_rtc_prescaler.sv
module sim_rtc_prescaler;
  localparam int N  = 6;
  localparam int F  = 1;
  localparam int M  = 1 << N;
  localparam int FM = (1 << F) - 1;

  logic clk = 1'b0;
  logic rst, stop_i, swrst_i, cnt_en_i, irq_req_i;
  logic [N-1:0] tap_o;
  logic tick_o, irq_o;

  int vectors = 0;
  int miscompares = 0;
  int m_cnt = 0;
  int cyc_since = 0;
  int first_tick = -1;

  always #2 clk = ~clk;

  rtc_prescaler #(.DIV_BITS(N), .FREE_BITS(F)) u0 (
    .clk(clk), .rst(rst), .stop_i(stop_i), .swrst_i(swrst_i),
    .cnt_en_i(cnt_en_i), .irq_req_i(irq_req_i),
    .tap_o(tap_o), .tick_o(tick_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic st, input logic sw, input logic en,
                      input logic rq, input string tag);
    int old_c, new_c, e_tap;
    logic e_tick, e_irq;
    stop_i = st; swrst_i = sw; cnt_en_i = en; irq_req_i = rq;
    old_c = m_cnt;
    if (sw) new_c = 0;
    else if ((old_c & FM) == FM) new_c = st ? (old_c & ~FM) : ((old_c + 1) % M);
    else new_c = old_c + 1;
    e_tap  = sw ? 0 : (old_c & ~new_c);
    e_tick = !sw && !st && (old_c == M - 1);
    e_irq  = rq & en & ~sw;
    m_cnt  = new_c;
    @(posedge clk); #1;
    check("R2", int'(tap_o[0]), e_tap & 1);
    check(tag, int'(tap_o[N-1:1]), e_tap >> 1);
    check((tag == "R3") ? "R4" : tag, int'(tick_o), int'(e_tick));
    check("R8", int'(irq_o), int'(e_irq));
    cyc_since++;
    if (tick_o && first_tick < 0) first_tick = cyc_since;
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; stop_i = 1'b0; swrst_i = 1'b0; cnt_en_i = 1'b0; irq_req_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(tap_o), 0);
    check("R1", int'(tick_o), 0);
    check("R1", int'(irq_o), 0);
    rst = 1'b0;
    m_cnt = 0; cyc_since = 0; first_tick = -1;
    for (int i = 0; i < 200; i++) step(1'b0, 1'b0, 1'b1, (i % 3) == 0, "R3");
    check("R1", first_tick, M);

    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, i[0], 1'b1, "R5");
    for (int i = 0; i < 100; i++) step(1'b0, 1'b0, 1'b1, i[1], "R6");

    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, "R7");
    cyc_since = 0; first_tick = -1;
    for (int i = 0; i < 130; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    check("R7", first_tick, M);

    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R3");

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic st, sw;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st = (lfsr[1:0] == 2'b00);
      sw = (lfsr[6:2] == 5'b10101);
      step(st, sw, lfsr[8], lfsr[9], st ? "R5" : "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule